// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a mobile SDRAM and owns the command pins from reset until the memory is fit for normal traffic. It first holds the bus in a no-operation state, with clock enable raised, for a stabilization time. It then issues the fixed bring-up series: precharge of every bank, two auto-refresh commands, a load of the base mode register, and a load of the extended mode register. Each command is followed by the gap the memory needs before it can take the next one. When the last gap has passed, the block raises `ready`, and a downstream controller may take over the pins from that point.

All waiting times are parameters given in nanoseconds, except the mode-register gap, which is given in clocks. At elaboration each time is turned into a clock count by rounding up against the clock period. The two mode-register opcodes come from input ports, so the integrating logic chooses burst and latency settings without touching the sequencer. When the memory leaves deep power-down it needs the complete series again. An exit request starts the whole series over from the stabilization wait, and this also applies when the request arrives partway through a series.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, `cke` and `ready` are low and the pins carry the no-operation pattern (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1, `ba`=0, `addr`=0).
- R2: After reset is released, or in the cycle after `dpd_exit_req` is sampled high, `cke` is high. It stays high from then on while `rst_n` is high. The pins carry no-operation for N_STABLE+1 consecutive cycles, counted from the restart cycle, before the first command.
- R3: The first command is precharge-all: `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `addr` bit 10 = 1, all other `addr` bits 0, `ba`=0. It appears N_STABLE+1 cycles after the restart cycle.
- R4: Auto refresh (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, `ba`=0, `addr`=0) is issued twice. The first comes N_RP cycles after the precharge and the second comes N_RFC cycles after the first.
- R5: The base mode-register load (`cs_n`,`ras_n`,`cas_n`,`we_n` all 0, `ba`=00, `addr`=`mode_op`) comes N_RFC cycles after the second refresh.
- R6: The extended mode-register load (same command pins, `ba`=10, `addr`=`ext_op`) comes N_MRD cycles after the base load, where N_MRD is MRD_CLKS but never less than 2.
- R7: `ready` rises N_MRD cycles after the extended load. It then stays high, with the pins at no-operation, until a restart.
- R8: A `dpd_exit_req` sampled high at any point, including partway through the series, restarts the series from the stabilization wait and drops `ready` in the next cycle.
- R9: Every cycle without a command drives the no-operation pattern with `ba`=0 and `addr`=0. Changing `mode_op` or `ext_op` has no effect outside the two load cycles.
- R10: Each count is ceil(time / CLK_PERIOD_PS) with a minimum of 1. N_STABLE comes from T_STABLE_NS, N_RP from T_RP_NS, and N_RFC from T_RFC_NS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dpd_exit_req | input | 1 | Restart the series (deep power-down exit) |
| mode_op | input | ADDR_W | Opcode for the base mode-register load |
| ext_op | input | ADDR_W | Opcode for the extended mode-register load |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address / opcode bus |
| ready | output | 1 | Series complete |

## Verification
The assertions assume three things about the inputs:
- `dpd_exit_req` is synchronous to `clk`.
- `mode_op` and `ext_op` carry meaningful values only in the two load cycles.
- MRD_CLKS resolves to at least two cycles, so each mode-register load is always followed by a no-operation cycle.

The stimulus changes every input just after a falling edge, so each value is stable across the rising edge that samples it. Restart requests are placed during the stabilization wait, between the two refreshes, and while `ready` is high. One request is also held for several cycles. The opcodes are changed only while the sequencer is idle at `ready`, which shows that they are not driven outside the load cycles.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        STP_STABLE = 3'd0,
        STP_PRE    = 3'd1,
        STP_REF_A  = 3'd2,
        STP_REF_B  = 3'd3,
        STP_MODE   = 3'd4,
        STP_EXT    = 3'd5,
        STP_READY  = 3'd6
    } step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam pins_t PINS_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam pins_t PINS_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam pins_t PINS_LOAD = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Rounds a time in picoseconds up to whole clocks, never below floor_clks.
    function automatic int unsigned ps_to_clks(longint unsigned t_ps,
                                               longint unsigned per_ps,
                                               int unsigned floor_clks);
        longint unsigned q;
        q = (t_ps + per_ps - 64'd1) / per_ps;
        if (q < longint'(floor_clks))
            return floor_clks;
        return int'(q);
    endfunction

endpackage

// File: rtl/sdram_init_gap.sv
// Reload value of the step counter on entry into a step.
module sdram_init_gap
    import sdram_init_pkg::*;
#(
    parameter int unsigned N_STABLE = 1,
    parameter int unsigned N_RP     = 1,
    parameter int unsigned N_RFC    = 1,
    parameter int unsigned N_MRD    = 2,
    parameter int unsigned CNT_W    = 4
) (
    input  step_e             step_in,
    output logic [CNT_W-1:0]  load_o
);

    always_comb begin
        unique case (step_in)
            STP_STABLE: load_o = CNT_W'(N_STABLE);
            STP_PRE:    load_o = CNT_W'(N_RP - 1);
            STP_REF_A,
            STP_REF_B:  load_o = CNT_W'(N_RFC - 1);
            STP_MODE,
            STP_EXT:    load_o = CNT_W'(N_MRD - 1);
            default:    load_o = '0;
        endcase
    end

endmodule

// File: rtl/sdram_init_cmd_enc.sv
// Maps the current step and its issue flag onto the memory command pins.
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned AP_BIT = 10
) (
    input  step_e              step_in,
    input  logic               issue,
    input  logic [ADDR_W-1:0]  mode_op,
    input  logic [ADDR_W-1:0]  ext_op,
    output pins_t              pins_o,
    output logic [BANK_W-1:0]  ba_o,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam logic [BANK_W-1:0] BA_BASE = '0;
    localparam logic [BANK_W-1:0] BA_EXT  = BANK_W'(2);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

    always_comb begin
        pins_o = PINS_NOP;
        ba_o   = '0;
        addr_o = '0;
        if (issue) begin
            unique case (step_in)
                STP_PRE: begin
                    pins_o = PINS_PRE;
                    addr_o = ALL_BANKS;
                end
                STP_REF_A,
                STP_REF_B: pins_o = PINS_REF;
                STP_MODE: begin
                    pins_o = PINS_LOAD;
                    ba_o   = BA_BASE;
                    addr_o = mode_op;
                end
                STP_EXT: begin
                    pins_o = PINS_LOAD;
                    ba_o   = BA_EXT;
                    addr_o = ext_op;
                end
                default: pins_o = PINS_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned T_STABLE_NS   = 200000,
    parameter int unsigned T_RP_NS       = 18,
    parameter int unsigned T_RFC_NS      = 110,
    parameter int unsigned MRD_CLKS      = 2,
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned BANK_W        = 2,
    parameter int unsigned AP_BIT        = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dpd_exit_req,
    input  logic [ADDR_W-1:0] mode_op,
    input  logic [ADDR_W-1:0] ext_op,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);

    // R10: elaboration-time conversion of times into clocks
    localparam int unsigned N_STABLE = ps_to_clks(longint'(T_STABLE_NS) * 64'd1000, longint'(CLK_PERIOD_PS), 1);
    localparam int unsigned N_RP     = ps_to_clks(longint'(T_RP_NS) * 64'd1000, longint'(CLK_PERIOD_PS), 1);
    localparam int unsigned N_RFC    = ps_to_clks(longint'(T_RFC_NS) * 64'd1000, longint'(CLK_PERIOD_PS), 1);
    localparam int unsigned N_MRD    = (MRD_CLKS < 2) ? 2 : MRD_CLKS;
    localparam int unsigned N_MAX_A  = (N_RP > N_RFC) ? N_RP : N_RFC;
    localparam int unsigned N_MAX_B  = (N_MAX_A > N_MRD) ? N_MAX_A : N_MRD;
    localparam int unsigned N_MAX    = (N_MAX_B > N_STABLE) ? N_MAX_B : N_STABLE;
    localparam int unsigned CNT_W    = $clog2(N_MAX + 1);

    typedef struct packed {
        step_e            step;
        logic [CNT_W-1:0] cnt;
        logic             issue;
        logic             cke;
        logic             ready;
    } seq_t;

    seq_t             st_d, st_q;
    step_e            step_nxt;
    logic [CNT_W-1:0] gap_load;
    pins_t            pins;

    assign step_nxt = (st_q.step == STP_READY) ? STP_READY : step_e'(st_q.step + 3'd1);

    sdram_init_gap #(
        .N_STABLE (N_STABLE),
        .N_RP     (N_RP),
        .N_RFC    (N_RFC),
        .N_MRD    (N_MRD),
        .CNT_W    (CNT_W)
    ) u_gap (
        .step_in (step_nxt),
        .load_o  (gap_load)
    );

    always_comb begin
        st_d       = st_q;
        st_d.issue = 1'b0;
        st_d.cke   = 1'b1;
        if (dpd_exit_req) begin
            st_d.step  = STP_STABLE;
            st_d.cnt   = CNT_W'(N_STABLE);
            st_d.ready = 1'b0;
        end else if (st_q.step != STP_READY) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.step  = step_nxt;
                st_d.cnt   = gap_load;
                st_d.issue = (step_nxt != STP_READY);
                st_d.ready = (step_nxt == STP_READY);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.step  <= STP_STABLE;
            st_q.cnt   <= CNT_W'(N_STABLE);
            st_q.issue <= 1'b0;
            st_q.cke   <= 1'b0;
            st_q.ready <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    sdram_init_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .AP_BIT (AP_BIT)
    ) u_enc (
        .step_in (st_q.step),
        .issue   (st_q.issue),
        .mode_op (mode_op),
        .ext_op  (ext_op),
        .pins_o  (pins),
        .ba_o    (ba),
        .addr_o  (addr)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign cke   = st_q.cke;
    assign ready = st_q.ready;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dpd_exit_req,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BANK_W-1:0] ba,
    input logic [ADDR_W-1:0] addr,
    input logic              ready
);

    logic is_nop, is_pre, is_load;
    assign is_nop  = !cs_n && ras_n && cas_n && we_n;
    assign is_pre  = !cs_n && !ras_n && cas_n && !we_n;
    assign is_load = !cs_n && !ras_n && !cas_n && !we_n;

    a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[AP_BIT]);

    a_r6_load_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> is_nop);

    a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (is_nop && ba == '0 && addr == '0));

    a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !dpd_exit_req) |=> ready);

    a_r8_restart_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_exit_req |=> (!ready && cke && is_nop));

    a_r7_ready_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(is_nop));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .AP_BIT (AP_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dpd_exit_req (dpd_exit_req),
    .cke          (cke),
    .cs_n         (cs_n),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .ba           (ba),
    .addr         (addr),
    .ready        (ready)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

    localparam int unsigned PER_PS   = 20000;
    localparam int unsigned STAB_NS  = 1000;
    localparam int unsigned RP_NS    = 18;
    localparam int unsigned RFC_NS   = 110;
    localparam int unsigned MRD      = 2;

    // R10: counts derived from the requirement formula
    localparam int NS   = (STAB_NS * 1000 + PER_PS - 1) / PER_PS;  // 50
    localparam int NRP  = (RP_NS * 1000 + PER_PS - 1) / PER_PS;    // 1
    localparam int NRFC = (RFC_NS * 1000 + PER_PS - 1) / PER_PS;   // 6
    localparam int NMRD = MRD;
    localparam int T_PRE  = NS + 1;
    localparam int T_REF1 = T_PRE + NRP;
    localparam int T_REF2 = T_REF1 + NRFC;
    localparam int T_MODE = T_REF2 + NRFC;
    localparam int T_EXT  = T_MODE + NMRD;
    localparam int T_RDY  = T_EXT + NMRD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dpd_exit_req = 1'b0;
    logic [12:0] mode_op = 13'h0032;
    logic [12:0] ext_op  = 13'h0041;
    logic        cke, cs_n, ras_n, cas_n, we_n, ready;
    logic [1:0]  ba;
    logic [12:0] addr;

    int checks = 0;
    int errors = 0;
    int since = 0;
    bit in_rst = 1'b1;

    always #10ns clk = ~clk;

    sdram_init_seq #(
        .CLK_PERIOD_PS (PER_PS),
        .T_STABLE_NS   (STAB_NS),
        .T_RP_NS       (RP_NS),
        .T_RFC_NS      (RFC_NS),
        .MRD_CLKS      (MRD)
    ) u_sdram_init_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .dpd_exit_req (dpd_exit_req),
        .mode_op      (mode_op),
        .ext_op       (ext_op),
        .cke          (cke),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .ba           (ba),
        .addr         (addr),
        .ready        (ready)
    );

    // Behavioural reference: cycles elapsed since the last restart.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since  <= 0;
            in_rst <= 1'b1;
        end else if (dpd_exit_req) begin
            since  <= 0;
            in_rst <= 1'b0;
        end else if (since < 1000000) begin
            since <= since + 1;
        end
    end

    task automatic compare();
        logic [3:0]  exp_pins;
        logic [1:0]  exp_ba;
        logic [12:0] exp_addr;
        logic        exp_cke, exp_rdy;
        string       tag;
        exp_pins = 4'b0111; exp_ba = 2'b00; exp_addr = '0;
        exp_cke  = !(in_rst && since == 0);
        exp_rdy  = (since >= T_RDY);
        tag = (since == 0 && in_rst) ? "R1" : "R2 R9";
        if (since == T_PRE)  begin exp_pins = 4'b0010; exp_addr = 13'h0400; tag = "R3"; end
        if (since == T_REF1) begin exp_pins = 4'b0001; tag = "R4 R10"; end
        if (since == T_REF2) begin exp_pins = 4'b0001; tag = "R4"; end
        if (since == T_MODE) begin exp_pins = 4'b0000; exp_addr = mode_op; tag = "R5"; end
        if (since == T_EXT)  begin exp_pins = 4'b0000; exp_addr = ext_op; exp_ba = 2'b10; tag = "R6"; end
        if (since >= T_RDY)  tag = "R7 R8";
        checks++;
        if ({cs_n, ras_n, cas_n, we_n} !== exp_pins || ba !== exp_ba || addr !== exp_addr ||
            cke !== exp_cke || ready !== exp_rdy) begin
            errors++;
            $display("FAIL %s at t=%0d: pins=%b ba=%b addr=%h cke=%b rdy=%b expected pins=%b ba=%b addr=%h cke=%b rdy=%b",
                     tag, since, {cs_n, ras_n, cas_n, we_n}, ba, addr, cke, ready,
                     exp_pins, exp_ba, exp_addr, exp_cke, exp_rdy);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        run(3);                       // R1: reset state
        rst_n = 1'b1;
        run(T_RDY + 10);              // R2..R7 full series from reset
        mode_op = 13'h1abc;           // R9: opcode change while ready
        ext_op  = 13'h0155;
        run(6);
        dpd_exit_req = 1'b1;          // R8: restart from ready
        run(1);
        dpd_exit_req = 1'b0;
        run(T_REF1 + 2);
        dpd_exit_req = 1'b1;          // R8: restart between refreshes
        run(1);
        dpd_exit_req = 1'b0;
        run(20);
        dpd_exit_req = 1'b1;          // R8: restart during stabilization, held
        run(3);
        dpd_exit_req = 1'b0;
        run(T_RDY + 5);
        rst_n = 1'b0;                 // R1: reset while ready
        run(2);
        rst_n = 1'b1;
        run(T_RDY + 4);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R7: bench did not complete");
        finish_run();
    end

endmodule